// File: doc/BRIEF.md
# Piecewise Quadratic Function Evaluator

This block is a purely combinational operator that returns a fixed-point approximation of f(x) = 1/(1+x) - 1/2 for an unsigned fractional input x in [0,1). The input word is split in two. The upper SEG_BITS bits pick one of 2^SEG_BITS equal sub-intervals. The remaining bits give the position inside that sub-interval. On each sub-interval the function is replaced by a quadratic expanded about the centre of the sub-interval's grid points. Its three monomials are formed side by side and then summed, with no iteration:

- The constant coefficient is read from a table indexed by the segment.
- The linear term is a segment-indexed slope times the folded offset, formed in a small multiplier.
- The quadratic term, whose weight is tiny, is read whole from a table. That table is addressed by only the upper QSEG_BITS bits of the segment and the upper QOFF_BITS bits of the offset.

All tables are computed at elaboration from the parameters. The adder works at OUT_W+GUARD bits. Half an output ulp is folded into the constant table, so the final truncation rounds to nearest. The result then stays within one output ulp of the true value.

The operator can sit in any datapath that needs this reciprocal-shaped curve, for example as a seed for iterative division. It has no clock and no state.

Top module: `pwpoly_eval`

## Requirements
- R1: For every input code X, the output Y satisfies |Y/2^OUT_W - f(X/2^IN_W)| < 2^-OUT_W, where f(x) = 1/(1+x) - 1/2.
- R2: Input code 0, where f is exactly 1/2, gives exactly the output code 2^(OUT_W-1) (0x800 with the defaults).
- R3: For every input code, the output code lies in [0, 2^(OUT_W-1)], and the internal sum never leaves [0, 2^(OUT_W+GUARD)).
- R4: The output depends only on the present input code. Applying a code again, after other codes, gives the same output code.
- R5: Codes m·2^(IN_W-SEG_BITS)-1 and m·2^(IN_W-SEG_BITS) lie on either side of a segment boundary. For every such pair, their output codes differ by at most 2.
- R6: The mean of Y/2^OUT_W - f(X/2^IN_W) over all input codes has magnitude below a quarter of 2^-OUT_W. This holds because the final truncation is centred by a folded half ulp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | IN_W | Unsigned fraction x = x_i / 2^IN_W. The upper SEG_BITS bits select the segment. |
| y_o | output | OUT_W | Unsigned fraction approximating f(x), in units of 2^-OUT_W. |

## Verification
The block has no state, so any corrupted table entry, wrong fold polarity or missing rounding offset shows at y_o in the same cycle as the affected input codes.

- A bad constant or slope entry moves every code of one segment.
- A bad entry in the quadratic table moves a whole group of segments at the offsets it covers.
- A wrong sign on the linear term appears as an error near the ends of every segment.

A sweep of every code against a real-valued model catches all of these within one pass. A centring fault can stay inside the one-ulp bound on many codes, but it shows up in the signed mean error.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    // fraction bits used for the intermediate reciprocal powers
    localparam int RQ = 31;

    // grid denominator of segment idx: the centre c of the segment satisfies
    // 1 + c = D / 2^(wi+1)
    function automatic logic [63:0] grid_den(input int wi, input int beta, input int idx);
        return (64'd1 << (wi + 1)) + (64'(2 * idx + 1) << beta) - 64'd1;
    endfunction

    // 1/(1+c) in Q31, rounded
    function automatic logic [63:0] inv_q(input int wi, input int beta, input int idx);
        logic [63:0] d;
        d = grid_den(wi, beta, idx);
        return ((64'd1 << (wi + 1 + RQ + 1)) + d) / (d << 1);
    endfunction

    // constant coefficient at acc_w fraction bits plus half an output ulp
    function automatic logic [63:0] k0_entry(input int wi, input int beta, input int acc_w,
                                             input int guard, input int idx);
        logic [63:0] d;
        logic [63:0] q;
        d = grid_den(wi, beta, idx);
        q = ((64'd1 << (wi + 2 + acc_w)) + d) / (d << 1);
        return q - (64'd1 << (acc_w - 1)) + (64'd1 << (guard - 1));
    endfunction

    // slope magnitude 1/(1+c)^2 at acc_w fraction bits
    function automatic logic [63:0] k1_entry(input int wi, input int beta, input int acc_w,
                                             input int idx);
        logic [63:0] r;
        r = inv_q(wi, beta, idx);
        return (r * r + (64'd1 << (2 * RQ - acc_w - 1))) >> (2 * RQ - acc_w);
    endfunction

    // curvature 1/(1+c)^3 in Q31
    function automatic logic [63:0] k2_q(input int wi, input int beta, input int idx);
        logic [63:0] r;
        logic [63:0] r2;
        r  = inv_q(wi, beta, idx);
        r2 = (r * r + (64'd1 << (RQ - 1))) >> RQ;
        return (r2 * r + (64'd1 << (RQ - 1))) >> RQ;
    endfunction

    // quadratic term for coarse segment j and coarse folded offset v:
    // average of the curvature at the extreme segments of the group, times the
    // square of the offset at the middle of the coarse cell
    function automatic logic [63:0] t2_entry(input int wi, input int beta, input int acc_w,
                                             input int alpha, input int qa, input int qb,
                                             input int j, input int v);
        logic [63:0] acc;
        logic [63:0] odd;
        int          span;
        int          s;
        int          sh;
        span = 1 << (alpha - qa);
        s    = beta - qb;
        sh   = RQ + 1 + 2 * (wi + 1) - 2 * s - acc_w;
        acc  = k2_q(wi, beta, j * span) + k2_q(wi, beta, j * span + span - 1);
        odd  = 64'(2 * v + 1);
        return (acc * odd * odd + (64'd1 << (sh - 1))) >> sh;
    endfunction

endpackage

// File: rtl/fpe_fold.sv
module fpe_fold #(
    parameter int OFF_W = 7
) (
    input  logic [OFF_W-1:0] off_i,
    output logic             upper_o,
    output logic [OFF_W-2:0] mag_o
);
    // upper half: offset above the grid centre, magnitude is the low bits;
    // lower half: mirrored by inverting the low bits
    always_comb begin
        upper_o = off_i[OFF_W-1];
        mag_o   = upper_o ? off_i[OFF_W-2:0] : ~off_i[OFF_W-2:0];
    end
endmodule

// File: rtl/fpe_seg_rom.sv
module fpe_seg_rom #(
    parameter int IN_W     = 12,
    parameter int SEG_BITS = 5,
    parameter int ACC_W    = 15,
    parameter int GUARD    = 3
) (
    input  logic [SEG_BITS-1:0] seg_i,
    output logic [ACC_W-1:0]    k0_o,
    output logic [ACC_W:0]      k1_o
);
    localparam int NSEG  = 1 << SEG_BITS;
    localparam int OFF_W = IN_W - SEG_BITS;

    logic [ACC_W-1:0] k0_tab [NSEG];
    logic [ACC_W:0]   k1_tab [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        assign k0_tab[i] = ACC_W'(fpe_pkg::k0_entry(IN_W, OFF_W, ACC_W, GUARD, i));
        assign k1_tab[i] = (ACC_W + 1)'(fpe_pkg::k1_entry(IN_W, OFF_W, ACC_W, i));
    end

    assign k0_o = k0_tab[seg_i];
    assign k1_o = k1_tab[seg_i];
endmodule

// File: rtl/fpe_lin_term.sv
module fpe_lin_term #(
    parameter int IN_W     = 12,
    parameter int SEG_BITS = 5,
    parameter int ACC_W    = 15
) (
    input  logic [ACC_W:0]          k1_i,
    input  logic [IN_W-SEG_BITS-2:0] mag_i,
    output logic [ACC_W-1:0]        t1_o
);
    localparam int OFF_W = IN_W - SEG_BITS;
    localparam int PW    = ACC_W + 1 + OFF_W + 1;
    localparam logic [PW-1:0] HALF = PW'(1) << IN_W;

    logic [OFF_W-1:0] odd_off;
    logic [PW-1:0]    prod;

    // |t| = (2*mag + 1) / 2^(IN_W+1); product is rounded back to ACC_W bits by
    // adding half an ulp before the truncating shift
    always_comb begin
        odd_off = {mag_i, 1'b1};
        prod    = PW'(k1_i) * PW'(odd_off);
        t1_o    = ACC_W'((prod + HALF) >> (IN_W + 1));
    end

    always_comb begin
        if (!$isunknown({k1_i, mag_i})) begin
            AST_LIN_BOUND: assert (32'(t1_o) <= 32'(k1_i >> (SEG_BITS + 1)) + 32'd1)
                else $error("linear term exceeds slope times half segment"); // R1
        end
    end
endmodule

// File: rtl/fpe_quad_rom.sv
module fpe_quad_rom #(
    parameter int IN_W      = 12,
    parameter int SEG_BITS  = 5,
    parameter int ACC_W     = 15,
    parameter int QSEG_BITS = 4,
    parameter int QOFF_BITS = 4
) (
    input  logic [QSEG_BITS-1:0] aq_i,
    input  logic [QOFF_BITS-2:0] bq_i,
    output logic [ACC_W-1:0]     t2_o
);
    localparam int OFF_W = IN_W - SEG_BITS;
    localparam int NA    = 1 << QSEG_BITS;
    localparam int NV    = 1 << (QOFF_BITS - 1);
    localparam int NT    = NA * NV;

    logic [ACC_W-1:0] t2_tab [NT];

    for (genvar j = 0; j < NA; j++) begin : g_qa
        for (genvar v = 0; v < NV; v++) begin : g_qb
            assign t2_tab[j * NV + v] = ACC_W'(fpe_pkg::t2_entry(IN_W, OFF_W, ACC_W, SEG_BITS,
                                                                 QSEG_BITS, QOFF_BITS, j, v));
        end
    end

    assign t2_o = t2_tab[{aq_i, bq_i}];

    always_comb begin
        if (!$isunknown({aq_i, bq_i})) begin
            AST_QUAD_BOUND: assert (32'(t2_o) <= (32'd1 << (ACC_W - 2 * SEG_BITS - 2)) + 32'd1)
                else $error("quadratic term above its weight"); // R1
        end
    end
endmodule

// File: rtl/pwpoly_eval.sv
module pwpoly_eval #(
    parameter int IN_W      = 12,
    parameter int OUT_W     = 12,
    parameter int SEG_BITS  = 5,
    parameter int GUARD     = 3,
    parameter int QSEG_BITS = 4,
    parameter int QOFF_BITS = 4
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [OUT_W-1:0] y_o
);
    localparam int OFF_W = IN_W - SEG_BITS;
    localparam int ACC_W = OUT_W + GUARD;
    localparam int SUM_W = ACC_W + 2;
    localparam logic [OUT_W-1:0] HALF_CODE = OUT_W'(1) << (OUT_W - 1);

    typedef struct packed {
        logic [SUM_W-1:0] base;
        logic [SUM_W-1:0] slope;
        logic [SUM_W-1:0] total;
    } sum_t;

    logic [SEG_BITS-1:0] seg;
    logic [OFF_W-1:0]    off;
    logic                upper;
    logic [OFF_W-2:0]    mag;
    logic [ACC_W-1:0]    k0;
    logic [ACC_W:0]      k1;
    logic [ACC_W-1:0]    t1;
    logic [ACC_W-1:0]    t2;
    sum_t                sum_d;

    assign seg = x_i[IN_W-1 -: SEG_BITS];
    assign off = x_i[OFF_W-1:0];

    fpe_fold #(.OFF_W(OFF_W)) u_fold (
        .off_i   (off),
        .upper_o (upper),
        .mag_o   (mag)
    );

    fpe_seg_rom #(
        .IN_W(IN_W), .SEG_BITS(SEG_BITS), .ACC_W(ACC_W), .GUARD(GUARD)
    ) u_seg (
        .seg_i (seg),
        .k0_o  (k0),
        .k1_o  (k1)
    );

    fpe_lin_term #(
        .IN_W(IN_W), .SEG_BITS(SEG_BITS), .ACC_W(ACC_W)
    ) u_lin (
        .k1_i  (k1),
        .mag_i (mag),
        .t1_o  (t1)
    );

    fpe_quad_rom #(
        .IN_W(IN_W), .SEG_BITS(SEG_BITS), .ACC_W(ACC_W),
        .QSEG_BITS(QSEG_BITS), .QOFF_BITS(QOFF_BITS)
    ) u_quad (
        .aq_i (seg[SEG_BITS-1 -: QSEG_BITS]),
        .bq_i (mag[OFF_W-2 -: QOFF_BITS-1]),
        .t2_o (t2)
    );

    // the slope is negative: above the grid centre the linear term is
    // subtracted, below it is added
    always_comb begin
        sum_d.base  = SUM_W'(k0) + SUM_W'(t2);
        sum_d.slope = SUM_W'(t1);
        sum_d.total = upper ? (sum_d.base - sum_d.slope) : (sum_d.base + sum_d.slope);
    end

    assign y_o = sum_d.total[ACC_W-1:GUARD];

    always_comb begin
        if (!$isunknown(x_i)) begin
            AST_SUM_RANGE: assert (sum_d.total < (SUM_W'(1) << ACC_W))
                else $error("internal sum outside [0,1)"); // R3
            AST_OUT_RANGE: assert (y_o <= HALF_CODE)
                else $error("output above one half"); // R3
            AST_ZERO_EXACT: assert (x_i != '0 || y_o == HALF_CODE)
                else $error("zero input not exact"); // R2
        end
    end
endmodule

// File: tb/sim_pwpoly_eval.sv
module sim_pwpoly_eval;
    localparam int IN_W     = 12;
    localparam int OUT_W    = 12;
    localparam int SEG_BITS = 5;
    localparam int NCODE    = 1 << IN_W;
    localparam int SEG_LEN  = 1 << (IN_W - SEG_BITS);
    localparam int NSEG     = 1 << SEG_BITS;
    localparam int HALF     = 1 << (OUT_W - 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IN_W-1:0]  x   = '0;
    logic [OUT_W-1:0] y;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    int  ytab [NCODE];
    real ulp    = 1.0 / real'(1 << OUT_W);
    real errsum = 0.0;

    always #5 clk = ~clk;

    pwpoly_eval #(.IN_W(IN_W), .OUT_W(OUT_W), .SEG_BITS(SEG_BITS)) u0 (
        .x_i (x),
        .y_o (y)
    );

    function automatic real ref_f(input int code);
        return 1.0 / (1.0 + real'(code) / real'(NCODE)) - 0.5;
    endfunction

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%f expected=%f", tag, act, exp);
        end
    endtask

    task automatic apply(input int code);
        @(posedge clk);
        #1 x = IN_W'(code);
        @(negedge clk);
    endtask

    initial begin
        // reset state: input held at zero
        x = '0;
        repeat (3) @(negedge clk);
        chk(y == OUT_W'(HALF), "R2 reset state code 0", real'(y), real'(HALF));
        rst = 1'b0;

        // R1, R3: every code against the real model, one code per clock
        for (int k = 0; k < NCODE; k++) begin
            real f;
            real e;
            apply(k);
            f = ref_f(k);
            e = real'(y) * ulp - f;
            ytab[k] = int'(y);
            errsum += e;
            chk(rabs(e) < ulp, $sformatf("R1 code %0d", k), real'(y) * ulp, f);
            chk(int'(y) <= HALF, $sformatf("R3 code %0d", k), real'(y), real'(HALF));
            if (k == 0)
                chk(y == OUT_W'(HALF), "R2 code 0 exact", real'(y), real'(HALF));
        end

        // R4: revisit codes in another order
        for (int k = NCODE - 1; k >= 0; k -= 37) begin
            apply(k);
            chk(int'(y) == ytab[k], $sformatf("R4 repeat code %0d", k), real'(y), real'(ytab[k]));
        end

        // R5: continuity across segment boundaries
        for (int m = 1; m < NSEG; m++) begin
            int d;
            d = ytab[m * SEG_LEN - 1] - ytab[m * SEG_LEN];
            chk(d >= -2 && d <= 2, $sformatf("R5 boundary %0d", m), real'(d), 0.0);
        end

        // R6: centred rounding, mean signed error
        begin
            real mean;
            mean = errsum / real'(NCODE);
            chk(rabs(mean) < 0.25 * ulp, "R6 mean error", mean, 0.0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule